// File: doc/BRIEF.md
# Fixed-Latency Release Matcher

This block decides when a received data word may be handed on, so that every word leaves a fixed number of clock cycles after the moment it was sent. The sender's timestamp arrives as a whole-seconds count (40 bits) and a cycle count within that second (28 bits). The block adds a configured latency, in cycles, to the cycle count. If the sum runs past the end of the second, the cycle count wraps and the seconds count carries by one. It stores the resulting target and raises a one-cycle release pulse once the local time reaches or passes it. The number of cycles in a second is a parameter, so a test bench can use a short second, and the target then wraps at the same point as the local time base.

The local time base is an input to the block. Matching only runs while its valid flag is high. Fixed-latency operation can be switched off, and then each accepted timestamp is released at once. Only one target can be pending at a time. A timestamp whose target already lies in the past when it arrives is released straight away and flagged as late.

Top module: `flt_release_match`

## Requirements
- R1: While reset is applied, and after it is removed until a timestamp is accepted, release_o, late_o and busy_o are all low.
- R2: When fl_enable_i is 0, an accepted timestamp produces release_o high in the cycle after the accepting edge. late_o stays 0 and busy_o stays 0.
- R3: When enabled, the target is computed as sum = ts_cyc_i + latency. If sum >= CYC_RANGE, the target is (ts_tai_i + 1, sum - CYC_RANGE). Otherwise it is (ts_tai_i, sum).
- R4: A pending target is matched at the first clock edge where time_valid_i is 1 and the local pair (local_tai_i, local_cyc_i) is greater than or equal to the target pair. The comparison looks at TAI first and uses the cycle count only when the TAI values are equal. release_o is high for exactly the cycle after that edge.
- R5: While time_valid_i is 0, no match takes place and a pending target stays pending. A timestamp accepted while time_valid_i is 0 is never treated as late.
- R6: A latency_i value above CYC_RANGE - 1 is used as CYC_RANGE - 1.
- R7: busy_o is high while a target is pending. A ts_valid_i pulse while busy_o is high is ignored: it produces no release and leaves the pending target unchanged.
- R8: With fl_enable_i = 1 and time_valid_i = 1, if the local time at the accepting edge is already greater than or equal to the target, release_o and late_o are both high in the next cycle and nothing is left pending.
- R9: late_o is only ever high in a cycle where release_o is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block |
| time_valid_i | input | 1 | Local time base is valid |
| local_tai_i | input | 40 | Local time, whole seconds |
| local_cyc_i | input | 28 | Local time, cycle within the second |
| fl_enable_i | input | 1 | 1 = hold until the target time, 0 = release at once |
| latency_i | input | 28 | Fixed latency in cycles |
| ts_valid_i | input | 1 | Timestamp strobe |
| ts_tai_i | input | 40 | Timestamp, whole seconds |
| ts_cyc_i | input | 28 | Timestamp, cycle within the second |
| release_o | output | 1 | One-cycle release pulse |
| late_o | output | 1 | The release was for a target already in the past |
| busy_o | output | 1 | A target is pending |

## Verification
The assertions take for granted that ts_cyc_i and local_cyc_i are always below CYC_RANGE. The range check on the stored target cycle depends on this. The stimulus only uses cycle values below the shortened second. It moves the local time by single-cycle steps, or by explicit jumps while the counter is frozen, so every target either lies ahead of a counter that reaches it exactly or is deliberately placed behind or across a second boundary. All inputs change on the falling clock edge, which keeps them stable around every sampling edge.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int TAI_W = 40;
  localparam int CYC_W = 28;

  typedef struct packed {
    logic [TAI_W-1:0] tai;
    logic [CYC_W-1:0] cyc;
  } flt_time_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } flt_state_e;
endpackage

// File: rtl/flt_rst_sync.sv
module flt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flt_target_calc.sv
module flt_target_calc
  import flt_pkg::*;
#(
  parameter int CYC_RANGE = 125_000_000
) (
  input  flt_time_t        ts,
  input  logic [CYC_W-1:0] latency,
  output flt_time_t        target
);
  localparam logic [CYC_W-1:0] LAT_MAX = CYC_W'(CYC_RANGE - 1);
  localparam logic [CYC_W:0]   RANGE_X = (CYC_W+1)'(CYC_RANGE);

  logic [CYC_W-1:0] lat_eff;
  logic [CYC_W:0]   sum;
  logic             wraps;

  always_comb begin
    lat_eff = (latency > LAT_MAX) ? LAT_MAX : latency;
    sum     = {1'b0, ts.cyc} + {1'b0, lat_eff};
    wraps   = (sum >= RANGE_X);
    if (wraps) begin
      target.cyc = CYC_W'(sum - RANGE_X);
      target.tai = ts.tai + TAI_W'(1);
    end else begin
      target.cyc = sum[CYC_W-1:0];
      target.tai = ts.tai;
    end
  end
endmodule

// File: rtl/flt_time_ge.sv
module flt_time_ge
  import flt_pkg::*;
(
  input  flt_time_t a,
  input  flt_time_t b,
  output logic      a_ge_b
);
  always_comb begin
    if (a.tai != b.tai) a_ge_b = (a.tai > b.tai);
    else                a_ge_b = (a.cyc >= b.cyc);
  end
endmodule

// File: rtl/flt_release_match.sv
module flt_release_match
  import flt_pkg::*;
#(
  parameter int CYC_RANGE  = 125_000_000,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               time_valid_i,
  input  logic [TAI_W-1:0]   local_tai_i,
  input  logic [CYC_W-1:0]   local_cyc_i,
  input  logic               fl_enable_i,
  input  logic [CYC_W-1:0]   latency_i,
  input  logic               ts_valid_i,
  input  logic [TAI_W-1:0]   ts_tai_i,
  input  logic [CYC_W-1:0]   ts_cyc_i,
  output logic               release_o,
  output logic               late_o,
  output logic               busy_o
);
  logic       rst_sync_n;
  flt_time_t  local_now;
  flt_time_t  ts_in;
  flt_time_t  tgt_new;
  flt_time_t  tgt_q, tgt_d;
  logic       tgt_en;
  logic       new_passed;
  logic       pend_reached;
  flt_state_e state_q, state_d;
  logic       rel_q, rel_d;
  logic       late_q, late_d;
  logic       accept;
  logic       match;

  flt_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign local_now = '{tai: local_tai_i, cyc: local_cyc_i};
  assign ts_in     = '{tai: ts_tai_i,    cyc: ts_cyc_i};

  flt_target_calc #(.CYC_RANGE(CYC_RANGE)) u_target (
    .ts      (ts_in),
    .latency (latency_i),
    .target  (tgt_new)
  );

  // incoming target already behind local time
  flt_time_ge u_ge_new (
    .a      (local_now),
    .b      (tgt_new),
    .a_ge_b (new_passed)
  );

  // stored target reached by local time
  flt_time_ge u_ge_pend (
    .a      (local_now),
    .b      (tgt_q),
    .a_ge_b (pend_reached)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    tgt_en  = 1'b0;
    rel_d   = 1'b0;
    late_d  = 1'b0;
    accept  = ts_valid_i && (state_q == ST_IDLE);
    match   = (state_q == ST_PEND) && time_valid_i && pend_reached;

    if (match) begin
      rel_d   = 1'b1;
      state_d = ST_IDLE;
    end else if (accept) begin
      if (!fl_enable_i) begin
        rel_d = 1'b1;
      end else if (time_valid_i && new_passed) begin
        rel_d  = 1'b1;
        late_d = 1'b1;
      end else begin
        state_d = ST_PEND;
        tgt_d   = tgt_new;
        tgt_en  = 1'b1;
      end
    end
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      rel_q   <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
      late_q  <= late_d;
    end
  end

  // target register, written only on capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tgt_q <= '0;
    else if (tgt_en)  tgt_q <= tgt_d;
  end

  assign release_o = rel_q;
  assign late_o    = late_q;
  assign busy_o    = (state_q == ST_PEND);
endmodule

// File: rtl/flt_release_match_chk.sv
module flt_release_match_chk
  import flt_pkg::*;
#(
  parameter int CYC_RANGE = 125_000_000
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             ts_valid_i,
  input logic             fl_enable_i,
  input logic             time_valid_i,
  input logic             release_o,
  input logic             late_o,
  input logic             busy_o,
  input logic [CYC_W-1:0] tgt_cyc
);
  localparam logic [CYC_W-1:0] RANGE_C = CYC_W'(CYC_RANGE);

  a_r9_late_needs_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    late_o |-> release_o);

  a_r7_release_not_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    release_o |-> !busy_o);

  a_r2_bypass_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && ts_valid_i && !fl_enable_i) |=> (release_o && !late_o && !busy_o));

  a_r5_hold_while_invalid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && !time_valid_i) |=> (busy_o && !release_o));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (release_o && !ts_valid_i) |=> !release_o);

  a_r6_target_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (tgt_cyc < RANGE_C));
endmodule

bind flt_release_match flt_release_match_chk #(.CYC_RANGE(CYC_RANGE)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .ts_valid_i   (ts_valid_i),
  .fl_enable_i  (fl_enable_i),
  .time_valid_i (time_valid_i),
  .release_o    (release_o),
  .late_o       (late_o),
  .busy_o       (busy_o),
  .tgt_cyc      (tgt_q.cyc)
);

// File: tb/flt_release_match_bench.sv
`timescale 1ns/1ps
module flt_release_match_bench;
  localparam int RANGE = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tv;
  logic [39:0] ltai;
  logic [27:0] lcyc;
  logic        en;
  logic [27:0] lat;
  logic        ts_valid;
  logic [39:0] ts_tai;
  logic [27:0] ts_cyc;
  logic        release_o, late_o, busy_o;

  always #4 clk = ~clk;

  flt_release_match #(.CYC_RANGE(RANGE)) u_flt_release_match (
    .clk(clk), .rst_n(rst_n), .time_valid_i(tv),
    .local_tai_i(ltai), .local_cyc_i(lcyc),
    .fl_enable_i(en), .latency_i(lat),
    .ts_valid_i(ts_valid), .ts_tai_i(ts_tai), .ts_cyc_i(ts_cyc),
    .release_o(release_o), .late_o(late_o), .busy_o(busy_o)
  );

  typedef struct {
    longint tai;
    longint cyc;
    bit     late;
    bit     need_tv;
    string  req;
  } item_t;

  item_t  q[$];
  item_t  mit;
  int     checks = 0;
  int     fails  = 0;
  bit     run    = 0;
  bit     mon_en = 0;
  bit     done   = 0;
  longint smp_tai, smp_cyc;
  bit     smp_tv;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // all driving happens on the falling edge; local time advances here
  task automatic tick();
    @(negedge clk);
    if (run) begin
      if (lcyc == 28'(RANGE - 1)) begin
        lcyc = '0;
        ltai = ltai + 40'd1;
      end else begin
        lcyc = lcyc + 28'd1;
      end
    end
  endtask

  task automatic set_local(longint t, longint c);
    ltai = 40'(t);
    lcyc = 28'(c);
  endtask

  // driver: present a timestamp for one edge, push what should come out
  task automatic send(longint t, longint c, longint l, bit e, bit expect_it,
                      longint et, longint ec, bit elate, bit etv, string req);
    item_t it;
    ts_tai   = 40'(t);
    ts_cyc   = 28'(c);
    lat      = 28'(l);
    en       = e;
    ts_valid = 1'b1;
    if (expect_it) begin
      it.tai = et; it.cyc = ec; it.late = elate; it.need_tv = etv; it.req = req;
      q.push_back(it);
    end
    tick();
    ts_valid = 1'b0;
  endtask

  task automatic wait_idle(int maxc, string req);
    for (int i = 0; i < maxc; i++) begin
      if (q.size() == 0 && !busy_o) break;
      tick();
    end
    chk(q.size() == 0 && !busy_o, req, "release outstanding", longint'(q.size()), 0);
  endtask

  // local time seen at each sampling edge
  always @(posedge clk) begin
    smp_tai <= longint'(ltai);
    smp_cyc <= longint'(lcyc);
    smp_tv  <= tv;
  end

  // monitor: pop and compare on every release
  always @(negedge clk) begin
    if (mon_en) begin
      if (late_o && !release_o) chk(1'b0, "R9", "late without release", 1, 0);
      if (release_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected release", 1, 0);
        end else begin
          mit = q.pop_front();
          chk(smp_tai == mit.tai, mit.req, "trigger tai", smp_tai, mit.tai);
          chk(smp_cyc == mit.cyc, mit.req, "trigger cyc", smp_cyc, mit.cyc);
          chk(late_o == mit.late, mit.req, "late flag", longint'(late_o), longint'(mit.late));
          if (mit.need_tv) chk(smp_tv, "R5", "match while time invalid", longint'(smp_tv), 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tv = 1'b0; ltai = '0; lcyc = '0;
    en = 1'b1; lat = '0; ts_valid = 1'b0; ts_tai = '0; ts_cyc = '0;
    repeat (3) @(negedge clk);
    chk(!release_o, "R1", "release in reset", longint'(release_o), 0);
    chk(!late_o,    "R1", "late in reset",    longint'(late_o), 0);
    chk(!busy_o,    "R1", "busy in reset",    longint'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(!release_o, "R1", "release after reset", longint'(release_o), 0);
    chk(!busy_o,    "R1", "busy after reset",    longint'(busy_o), 0);
    mon_en = 1'b1;
    tv = 1'b1; run = 1'b1;
    set_local(1, 0);

    // R2: bypass mode
    send(1, 5, 300, 1'b0, 1'b1, longint'(ltai), longint'(lcyc), 1'b0, 1'b0, "R2");
    tick();
    chk(!busy_o, "R2", "busy in bypass", longint'(busy_o), 0);
    wait_idle(10, "R2");

    // R3: target inside the second
    tick(); set_local(2, 100);
    send(2, 100, 50, 1'b1, 1'b1, 2, 150, 1'b0, 1'b1, "R3");
    tick();
    chk(busy_o, "R7", "busy while pending", longint'(busy_o), 1);
    wait_idle(2000, "R3");

    // R3: carry into next second; R7: strobe while busy is ignored
    tick(); set_local(3, 900);
    send(3, 900, 300, 1'b1, 1'b1, 4, 200, 1'b0, 1'b1, "R3");
    repeat (3) tick();
    send(3, 0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, "R7");
    chk(busy_o, "R7", "busy after ignored strobe", longint'(busy_o), 1);
    wait_idle(2000, "R3");

    // R6: oversized latency clamped
    tick(); set_local(5, 0);
    send(5, 0, 5000, 1'b1, 1'b1, 5, 999, 1'b0, 1'b1, "R6");
    wait_idle(2000, "R6");
    tick(); set_local(6, 10);
    send(6, 10, 999, 1'b1, 1'b1, 7, 9, 1'b0, 1'b1, "R6");
    wait_idle(2000, "R6");

    // R8: late cases (behind, equal, behind across a second)
    tick(); set_local(8, 500);
    send(8, 100, 10, 1'b1, 1'b1, 8, 500, 1'b1, 1'b0, "R8");
    wait_idle(10, "R8");
    tick(); set_local(9, 400);
    send(9, 400, 0, 1'b1, 1'b1, 9, 400, 1'b1, 1'b0, "R8");
    wait_idle(10, "R8");
    tick(); set_local(11, 20);
    send(10, 995, 10, 1'b1, 1'b1, 11, 20, 1'b1, 1'b0, "R8");
    wait_idle(10, "R8");

    // R4: TAI compared before cycle count, frozen clock with jumps
    run = 1'b0;
    tick(); set_local(40, 900);
    send(41, 100, 0, 1'b1, 1'b1, 42, 0, 1'b0, 1'b1, "R4");
    repeat (5) tick();
    chk(busy_o, "R4", "larger cyc smaller tai matched", longint'(busy_o), 1);
    set_local(41, 50);
    repeat (5) tick();
    chk(busy_o, "R4", "same tai smaller cyc matched", longint'(busy_o), 1);
    set_local(42, 0);
    wait_idle(10, "R4");

    // R5: time invalid at capture and while pending
    tv = 1'b0;
    tick(); set_local(50, 20);
    send(50, 10, 0, 1'b1, 1'b1, 50, 20, 1'b0, 1'b1, "R5");
    repeat (10) tick();
    chk(busy_o, "R5", "pending while time invalid", longint'(busy_o), 1);
    tv = 1'b1;
    wait_idle(10, "R5");

    repeat (5) tick();
    chk(q.size() == 0, "R4", "leftover expected releases", longint'(q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule